// File: doc/BRIEF.md
# Motor Lock Fault Supervisor

This block sits beside the commutation logic of a brushless motor controller and decides when the motor must stop being driven. It receives six single-cycle detect pulses. Five come from independent lock-detection schemes and one from a no-motor detector. A 6-bit enable mask chooses which of those detections may stop the motor. Every detection is recorded in a status register, whether or not it is enabled, and software can read that register at any time through a synchronous read port.

When an enabled detection arrives while the motor is driven, the block puts the power stage into high impedance. At the same moment it requests an anti-voltage-surge sequence, so the energy left in the windings cannot pump the supply. It holds that request until the surge logic reports completion. It then counts a programmable lock-off time and issues a one-cycle restart request. The restart request also clears the recorded status, and the driven state resumes.

Top module: `lock_fault_supervisor`

## Requirements
- R1: After a synchronous reset the outputs are as follows: `hiz_o`, `avs_req_o` and `restart_req_o` are 0, the status register is 0, and a read returns 0.
- R2: `detect_i[k]` high in a cycle sets status bit k at the next clock edge, even when `enable_i[k]` is 0. Bits 4..0 are lock schemes 0..4 and bit 5 is the no-motor condition. Bits already set stay set.
- R3: A detection whose enable bit is 0 never takes the motor out of the driven state, so `hiz_o` stays 0.
- R4: Suppose `detect_i & enable_i` is non-zero while the motor is driven, or in the restart cycle. In the next cycle `hiz_o` and `avs_req_o` are both 1.
- R5: `avs_req_o` stays 1 for as long as `avs_done_i` is low. In the cycle after `avs_done_i` is sampled high, `avs_req_o` is 0 and `hiz_o` stays 1.
- R6: `off_cycles_i` is sampled on the edge that takes `avs_done_i`. The off wait with `hiz_o`=1 then lasts exactly `off_cycles_i`+1 cycles. It is followed by one cycle with `restart_req_o`=1 and `hiz_o`=0, and then by the driven state.
- R7: Detections during the surge wait or the off wait set their status bits but do not lengthen the surge wait or the off wait.
- R8: The restart cycle clears the status register. A detection that arrives in that same cycle is still recorded, because setting wins over clearing.
- R9: With `rd_en_i` high, `rd_data_o` shows the status register from that cycle in the next cycle. With `rd_en_i` low, `rd_data_o` holds its value.
- R10: Several enabled detections in the same cycle set all of their bits and start a single shutdown sequence with one restart request.
- R11: An enabled detection in the restart cycle starts a new shutdown sequence at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| detect_i | input | SRC_N | Detect pulses (bit 5 no-motor, bits 4..0 lock schemes) |
| enable_i | input | SRC_N | Per-condition enable for the protective action |
| off_cycles_i | input | OFF_W | Lock-off time in cycles |
| avs_done_i | input | 1 | Surge-suppression sequence finished |
| rd_en_i | input | 1 | Status read strobe |
| rd_data_o | output | SRC_N | Status read data, one cycle after the strobe |
| hiz_o | output | 1 | Power stage held in high impedance |
| avs_req_o | output | 1 | Surge-suppression request |
| restart_req_o | output | 1 | One-cycle motor restart request |

## Verification
The hardest situation to reach is a detection that coincides with the single restart cycle. In that cycle the status clear and the bit set meet, and a new shutdown must start without the block first returning to the driven state. The stimulus reaches it by counting the off-wait cycles at the ports until `restart_req_o` appears, and then driving an enabled detect pulse on that exact cycle. A second scenario places detect pulses inside both the surge wait and the off wait and reads status through the read port while the count is still running.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_AVS      = 2'd1,
        ST_OFF_WAIT = 2'd2,
        ST_RESTART  = 2'd3
    } lfs_state_e;

    localparam int unsigned NOMOTOR_BIT = 5;
endpackage

// File: rtl/lfs_status_reg.sv
module lfs_status_reg #(
    parameter int unsigned SRC_N = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] set_i,
    input  logic             clr_i,
    input  logic             rd_en_i,
    output logic [SRC_N-1:0] status_o,
    output logic [SRC_N-1:0] rd_data_o
);
    typedef struct packed {
        logic [SRC_N-1:0] status;
        logic [SRC_N-1:0] rd_data;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set has priority over the restart clear
        st_d.status = (clr_i ? '0 : st_q.status) | set_i;
        if (rd_en_i) begin
            st_d.rd_data = st_q.status;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o  = st_q.status;
    assign rd_data_o = st_q.rd_data;
endmodule

// File: rtl/lfs_off_timer.sv
module lfs_off_timer #(
    parameter int unsigned OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [OFF_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    typedef struct packed {
        logic [OFF_W-1:0] cnt;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (load_i) begin
            tm_d.cnt = load_val_i;
        end else if (dec_i && (tm_q.cnt != '0)) begin
            tm_d.cnt = tm_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign zero_o = (tm_q.cnt == '0);
endmodule

// File: rtl/lock_fault_supervisor.sv
module lock_fault_supervisor
    import lfs_pkg::*;
#(
    parameter int unsigned SRC_N = 6,
    parameter int unsigned OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] detect_i,
    input  logic [SRC_N-1:0] enable_i,
    input  logic [OFF_W-1:0] off_cycles_i,
    input  logic             avs_done_i,
    input  logic             rd_en_i,
    output logic [SRC_N-1:0] rd_data_o,
    output logic             hiz_o,
    output logic             avs_req_o,
    output logic             restart_req_o
);
    typedef struct packed {
        lfs_state_e state;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic [SRC_N-1:0] status_w;
    logic             trip_w;
    logic             tmr_load_w;
    logic             tmr_dec_w;
    logic             tmr_zero_w;
    logic             clr_w;

    assign trip_w = |(detect_i & enable_i);

    always_comb begin
        fsm_d      = fsm_q;
        tmr_load_w = 1'b0;
        tmr_dec_w  = 1'b0;
        unique case (fsm_q.state)
            ST_RUN, ST_RESTART: begin
                fsm_d.state = trip_w ? ST_AVS : ST_RUN;
            end
            ST_AVS: begin
                if (avs_done_i) begin
                    tmr_load_w  = 1'b1;
                    fsm_d.state = ST_OFF_WAIT;
                end
            end
            ST_OFF_WAIT: begin
                if (tmr_zero_w) begin
                    fsm_d.state = ST_RESTART;
                end else begin
                    tmr_dec_w = 1'b1;
                end
            end
            default: fsm_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q.state <= ST_RUN;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign clr_w         = (fsm_q.state == ST_RESTART);
    assign hiz_o         = (fsm_q.state == ST_AVS) || (fsm_q.state == ST_OFF_WAIT);
    assign avs_req_o     = (fsm_q.state == ST_AVS);
    assign restart_req_o = clr_w;

    lfs_status_reg #(.SRC_N(SRC_N)) u_status (
        .clk       (clk),
        .rst       (rst),
        .set_i     (detect_i),
        .clr_i     (clr_w),
        .rd_en_i   (rd_en_i),
        .status_o  (status_w),
        .rd_data_o (rd_data_o)
    );

    lfs_off_timer #(.OFF_W(OFF_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load_w),
        .load_val_i (off_cycles_i),
        .dec_i      (tmr_dec_w),
        .zero_o     (tmr_zero_w)
    );
endmodule

// File: rtl/lfs_checker.sv
module lfs_checker #(
    parameter int unsigned SRC_N = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [SRC_N-1:0] detect_i,
    input logic [SRC_N-1:0] enable_i,
    input logic             avs_done_i,
    input logic             rd_en_i,
    input logic [SRC_N-1:0] rd_data_o,
    input logic             hiz_o,
    input logic             avs_req_o,
    input logic             restart_req_o,
    input logic [SRC_N-1:0] status
);
    // R2: every detection is recorded at the next edge
    a_r2_detect_sets: assert property (@(posedge clk) disable iff (rst)
        (|detect_i) |=> ((status & $past(detect_i)) == $past(detect_i)));

    // R3: a driven motor with no enabled detection stays driven
    a_r3_masked_keeps_drive: assert property (@(posedge clk) disable iff (rst)
        (!hiz_o && !(|(detect_i & enable_i))) |=> !hiz_o);

    // R4: an enabled detection while driving starts the shutdown
    a_r4_trip_to_avs: assert property (@(posedge clk) disable iff (rst)
        (!hiz_o && (|(detect_i & enable_i))) |=> (hiz_o && avs_req_o));

    // R5: the surge request ends only after completion is reported
    a_r5_avs_hold: assert property (@(posedge clk) disable iff (rst)
        (avs_req_o && !avs_done_i) |=> avs_req_o);

    // R5: a surge request implies high impedance
    a_r5_avs_in_hiz: assert property (@(posedge clk) disable iff (rst)
        avs_req_o |-> hiz_o);

    // R6: the restart request is a single cycle and never overlaps high impedance
    a_r6_restart_pulse: assert property (@(posedge clk) disable iff (rst)
        restart_req_o |=> !restart_req_o);
    a_r6_restart_driven: assert property (@(posedge clk) disable iff (rst)
        restart_req_o |-> !hiz_o);

    // R8: restart clears status, detections in that cycle survive
    a_r8_restart_clear: assert property (@(posedge clk) disable iff (rst)
        restart_req_o |=> (status == $past(detect_i)));

    // R9: read data follows a strobe and holds otherwise
    a_r9_read: assert property (@(posedge clk) disable iff (rst)
        rd_en_i |=> (rd_data_o == $past(status)));
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> $stable(rd_data_o));
endmodule

bind lock_fault_supervisor lfs_checker #(.SRC_N(SRC_N)) u_lfs_chk (
    .clk           (clk),
    .rst           (rst),
    .detect_i      (detect_i),
    .enable_i      (enable_i),
    .avs_done_i    (avs_done_i),
    .rd_en_i       (rd_en_i),
    .rd_data_o     (rd_data_o),
    .hiz_o         (hiz_o),
    .avs_req_o     (avs_req_o),
    .restart_req_o (restart_req_o),
    .status        (status_w)
);

// File: tb/lock_fault_supervisor_tb.sv
`timescale 1ns/1ps
module lock_fault_supervisor_tb_top;
    localparam int unsigned SRC_N = 6;
    localparam int unsigned OFF_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic [SRC_N-1:0] detect_i;
    logic [SRC_N-1:0] enable_i;
    logic [OFF_W-1:0] off_cycles_i;
    logic             avs_done_i;
    logic             rd_en_i;
    logic [SRC_N-1:0] rd_data_o;
    logic             hiz_o;
    logic             avs_req_o;
    logic             restart_req_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    lock_fault_supervisor #(.SRC_N(SRC_N), .OFF_W(OFF_W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .detect_i      (detect_i),
        .enable_i      (enable_i),
        .off_cycles_i  (off_cycles_i),
        .avs_done_i    (avs_done_i),
        .rd_en_i       (rd_en_i),
        .rd_data_o     (rd_data_o),
        .hiz_o         (hiz_o),
        .avs_req_o     (avs_req_o),
        .restart_req_o (restart_req_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic read_status(output logic [SRC_N-1:0] v);
        rd_en_i = 1'b1;
        step();
        rd_en_i = 1'b0;
        v = rd_data_o;
    endtask

    task automatic pulse(input logic [SRC_N-1:0] d);
        detect_i = d;
        step();
        detect_i = '0;
    endtask

    // From the surge wait: finish it, count the off wait, stop on the restart cycle
    task automatic finish_seq(input int lval);
        int n;
        avs_done_i   = 1'b1;
        off_cycles_i = OFF_W'(lval);
        step();
        avs_done_i = 1'b0;
        chk(avs_req_o == 1'b0 && hiz_o == 1'b1, "R5 after done", {avs_req_o, hiz_o}, 2'b01);
        n = 0;
        while (hiz_o && n < 100000) begin
            n++;
            step();
        end
        chk(n == lval + 1, "R6 off wait length", n, lval + 1);
        chk(restart_req_o == 1'b1 && hiz_o == 1'b0, "R6 restart pulse", {restart_req_o, hiz_o}, 2'b10);
    endtask

    task automatic t_reset();
        logic [SRC_N-1:0] v;
        chk({hiz_o, avs_req_o, restart_req_o} == 3'b000, "R1 outputs", {hiz_o, avs_req_o, restart_req_o}, 0);
        chk(rd_data_o == '0, "R1 read data", rd_data_o, 0);
        read_status(v);
        chk(v == '0, "R1 status", v, 0);
    endtask

    task automatic t_masked();
        logic [SRC_N-1:0] v;
        enable_i = 6'b000000;
        pulse(6'b101010);
        for (int i = 0; i < 4; i++) begin
            chk(hiz_o == 1'b0, "R3 masked stays driven", hiz_o, 0);
            step();
        end
        read_status(v);
        chk(v == 6'b101010, "R2 masked bits recorded", v, 6'b101010);
        enable_i = 6'b010101;
        pulse(6'b101010);
        chk(hiz_o == 1'b0, "R3 partial mask", hiz_o, 0);
        read_status(v);
        chk(v == 6'b101010, "R2 bits persist", v, 6'b101010);
    endtask

    task automatic t_read_hold();
        logic [SRC_N-1:0] v;
        enable_i = '0;
        v = rd_data_o;
        pulse(6'b000001);
        step();
        chk(rd_data_o == v, "R9 hold without strobe", rd_data_o, v);
        read_status(v);
        chk(v == 6'b101011, "R9 read after strobe", v, 6'b101011);
    endtask

    task automatic t_shutdown();
        logic [SRC_N-1:0] v;
        enable_i = 6'b111111;
        pulse(6'b100000);
        chk(hiz_o && avs_req_o, "R4 no-motor trip", {hiz_o, avs_req_o}, 2'b11);
        for (int i = 0; i < 3; i++) begin
            step();
            chk(avs_req_o == 1'b1, "R5 avs held", avs_req_o, 1);
        end
        read_status(v);
        chk(v == 6'b101011, "R2 status during avs", v, 6'b101011);
        finish_seq(5);
        step();
        chk(restart_req_o == 1'b0 && hiz_o == 1'b0, "R6 back to run", {restart_req_o, hiz_o}, 0);
        read_status(v);
        chk(v == '0, "R8 cleared by restart", v, 0);
    endtask

    task automatic t_multi();
        logic [SRC_N-1:0] v;
        int restarts;
        enable_i = 6'b111111;
        pulse(6'b110011);
        chk(hiz_o && avs_req_o, "R10 one trip", {hiz_o, avs_req_o}, 2'b11);
        read_status(v);
        chk(v == 6'b110011, "R10 all bits set", v, 6'b110011);
        finish_seq(2);
        restarts = 0;
        for (int i = 0; i < 6; i++) begin
            step();
            if (restart_req_o || hiz_o) restarts++;
        end
        chk(restarts == 0, "R10 single sequence", restarts, 0);
    endtask

    task automatic t_during_wait();
        logic [SRC_N-1:0] v;
        int n;
        enable_i = 6'b111111;
        pulse(6'b000010);
        pulse(6'b000100);
        chk(avs_req_o == 1'b1, "R7 avs unchanged by detect", avs_req_o, 1);
        read_status(v);
        chk(v == 6'b000110, "R7 status during avs", v, 6'b000110);
        avs_done_i   = 1'b1;
        off_cycles_i = OFF_W'(6);
        step();
        avs_done_i = 1'b0;
        n = 0;
        v = '0;
        while (hiz_o && n < 100000) begin
            n++;
            if (n == 2) detect_i = 6'b001000;
            if (n == 3) begin detect_i = '0; rd_en_i = 1'b1; end
            if (n == 4) begin rd_en_i = 1'b0; v = rd_data_o; end
            step();
        end
        chk(n == 7, "R7 off wait not extended", n, 7);
        chk(v == 6'b001110, "R7 status during off wait", v, 6'b001110);
        chk(restart_req_o == 1'b1, "R7 restart still issued", restart_req_o, 1);
        step();
    endtask

    task automatic t_restart_hit();
        logic [SRC_N-1:0] v;
        enable_i = 6'b000001;
        pulse(6'b000001);
        finish_seq(0);
        pulse(6'b000001);
        chk(hiz_o && avs_req_o, "R11 trip in restart cycle", {hiz_o, avs_req_o}, 2'b11);
        read_status(v);
        chk(v == 6'b000001, "R8 set wins over clear", v, 1);
        finish_seq(1);
        step();
        chk(hiz_o == 1'b0, "R11 recovers", hiz_o, 0);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        rst = 1'b1; detect_i = '0; enable_i = '0; off_cycles_i = '0;
        avs_done_i = 1'b0; rd_en_i = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_masked();
        t_read_hold();
        t_shutdown();
        t_multi();
        t_during_wait();
        t_restart_hit();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
            $finish;
        end
    end
endmodule